// File: doc/BRIEF.md
# Pipelined Byte-Writable Synchronous SRAM

This block is a synchronous static memory for use as a cache or buffer store inside a larger chip. Every control, address and write-data input is captured on the rising clock edge, and read data passes through a second register before it reaches the output, so a read returns its word two edges after it is presented. The word is split into byte lanes. A write can cover the whole word through a single all-lanes strobe, or only the lanes picked by a per-lane strobe vector that counts only while a separate lane-gate input is low. The write completes from the captured inputs with no external pulse shaping.

The memory responds only when three selects agree. Anything else is a deselect cycle. The output-drive indication follows a double-cycle deselect rule: after a read, the first deselect does not cut the drivers. The captured read word stays on the bus for one more cycle before the drive indication falls. An asynchronous active-low output enable gates the drive indication directly. A live write command on the inputs also blanks it, so that the shared data bus can turn around. A doze input parks the block: commands are dropped, the drive indication is low, and the array and output register keep their contents until doze falls.

The address comes from an external burst sequencer, and the lane width is a parameter: 8 bits for plain organisations, 9 bits where each byte carries a parity bit.

Top module: `pipe_sram`

## Requirements
- R1: While reset is applied and after its release, `bus_drive` is low and `rdata` is zero until a read has completed.
- R2: A read presented at rising edge e updates `rdata` to the addressed word at edge e+1, not earlier. From e+1, `bus_drive` is high provided `out_en_n` is low, `doze` is low and no write is on the inputs.
- R3: The block is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other combination is a deselect cycle that writes nothing and reads nothing.
- R4: A selected cycle with `wr_all_n`=0 writes every lane of the word, whatever `wr_lane_gate_n` and `wr_lane_n` hold.
- R5: With `wr_all_n`=1 and `wr_lane_gate_n`=0, lane i is written exactly when `wr_lane_n[i]`=0. Lane i is bits [i*LANE_W +: LANE_W]. The other lanes keep their contents.
- R6: A selected cycle with `wr_all_n`=1 and either `wr_lane_gate_n`=1 or all `wr_lane_n` bits high is a read and leaves the array unchanged.
- R7: Double-cycle deselect: a read at edge e followed only by deselects keeps `bus_drive` high after edges e+1 and e+2, with `rdata` held, and low after edge e+3.
- R8: `out_en_n`=1 forces `bus_drive` low at once, without waiting for a clock edge.
- R9: A selected write command on the inputs forces `bus_drive` low in the same cycle. After the write is captured, the next edge leaves `bus_drive` low.
- R10: While `doze`=1, commands are ignored and `bus_drive` is low. Array contents and `rdata` are preserved, and normal operation resumes when `doze` returns to 0.
- R11: A word written at edge e is returned by a read presented at edge e+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs captured on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W | Word address from the burst sequencer |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_lane_gate_n | input | 1 | Qualifies the per-lane strobes, active low |
| wr_lane_n | input | LANES | Per-lane write strobes, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| doze | input | 1 | Power-down request; state preserved |
| wdata | input | LANES*LANE_W | Write data, captured with the command |
| rdata | output | LANES*LANE_W | Registered read data |
| bus_drive | output | 1 | High when the data bus drivers are on |

## Verification
A wrong capture-stage command kind shows up as a missing or stray `bus_drive` pulse one edge later, or as `rdata` changing when it should hold. A corrupted lane mask shows up as a wrong lane in the word read back two edges after the next read. If the deselect history is off by one, `bus_drive` falls one cycle early or late after a read. That difference is visible within three edges of the last read. Stale doze handling shows up as drive during doze or as a lost word after wake-up.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;
  typedef enum logic [1:0] {
    K_DESEL = 2'd0,
    K_READ  = 2'd1,
    K_WRITE = 2'd2,
    K_SLEEP = 2'd3
  } cmd_kind_e;
endpackage

// File: rtl/pipe_sram_rstsync.sv
module pipe_sram_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pipe_sram_decode.sv
module pipe_sram_decode
  import pipe_sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             wr_all_n,
  input  logic             wr_lane_gate_n,
  input  logic [LANES-1:0] wr_lane_n,
  input  logic             doze,
  output cmd_kind_e        kind,
  output logic [LANES-1:0] lane_mask,
  output logic             wr_live
);
  logic chip_sel;

  always_comb begin
    chip_sel = !sel_a_n && sel_b && !sel_c_n;
    // All-lanes strobe dominates; lane strobes count only when gated
    if (!wr_all_n)            lane_mask = '1;
    else if (!wr_lane_gate_n) lane_mask = ~wr_lane_n;
    else                      lane_mask = '0;

    if (doze)            kind = K_SLEEP;
    else if (!chip_sel)  kind = K_DESEL;
    else if (|lane_mask) kind = K_WRITE;
    else                 kind = K_READ;

    wr_live = (kind == K_WRITE);
  end
endmodule

// File: rtl/pipe_sram_inreg.sv
module pipe_sram_inreg
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_kind_e         kind_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic [LANES-1:0]  mask_in,
  output cmd_kind_e         s1_kind,
  output cmd_kind_e         s1_prev,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [DATA_W-1:0] s1_wdata,
  output logic [LANES-1:0]  s1_mask
);
  cmd_kind_e         kind_d, prev_d;
  logic              addr_ce, data_ce;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wdata_d;
  logic [LANES-1:0]  mask_d;

  // Next-state: explicit clock enables on the wide payload
  always_comb begin
    kind_d  = kind_in;
    prev_d  = s1_kind;
    addr_ce = (kind_in == K_READ) || (kind_in == K_WRITE);
    data_ce = (kind_in == K_WRITE);
    addr_d  = addr_ce ? addr_in  : s1_addr;
    wdata_d = data_ce ? wdata_in : s1_wdata;
    mask_d  = data_ce ? mask_in  : s1_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_kind <= K_DESEL;
      s1_prev <= K_DESEL;
    end else begin
      s1_kind <= kind_d;
      s1_prev <= prev_d;
    end
  end

  always_ff @(posedge clk) begin
    s1_addr  <= addr_d;
    s1_wdata <= wdata_d;
    s1_mask  <= mask_d;
  end
endmodule

// File: rtl/pipe_sram_array.sv
module pipe_sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  mask,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_d;

  // Self-timed write from the captured stage
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int l = 0; l < LANES; l++) begin
        if (mask[l]) mem[addr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
      end
    end
  end

  always_comb begin
    rd_d = rd_en ? mem[addr] : rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_d;
  end
endmodule

// File: rtl/pipe_sram_drive.sv
module pipe_sram_drive
  import pipe_sram_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cmd_kind_e s1_kind,
  input  cmd_kind_e s1_prev,
  input  logic      out_en_n,
  input  logic      doze,
  input  logic      wr_live,
  output logic      drv_q,
  output logic      bus_drive
);
  logic drv_d;

  // A read turns drivers on; the first deselect after a read keeps them on
  always_comb begin
    drv_d = (s1_kind == K_READ) ||
            ((s1_kind == K_DESEL) && (s1_prev == K_READ));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_q <= 1'b0;
    else        drv_q <= drv_d;
  end

  assign bus_drive = drv_q && !out_en_n && !doze && !wr_live;
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              wr_all_n,
  input  logic              wr_lane_gate_n,
  input  logic [LANES-1:0]  wr_lane_n,
  input  logic              out_en_n,
  input  logic              doze,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              bus_drive
);
  logic              rst_sync_n;
  cmd_kind_e         kind_in, s1_kind, s1_prev;
  logic [LANES-1:0]  mask_in, s1_mask;
  logic              wr_live, drv_q;
  logic [ADDR_W-1:0] s1_addr;
  logic [DATA_W-1:0] s1_wdata;

  pipe_sram_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  pipe_sram_decode #(.LANES(LANES)) u_dec (
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .wr_all_n(wr_all_n), .wr_lane_gate_n(wr_lane_gate_n),
    .wr_lane_n(wr_lane_n), .doze(doze),
    .kind(kind_in), .lane_mask(mask_in), .wr_live(wr_live)
  );

  pipe_sram_inreg #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_in (
    .clk(clk), .rst_n(rst_sync_n),
    .kind_in(kind_in), .addr_in(addr), .wdata_in(wdata), .mask_in(mask_in),
    .s1_kind(s1_kind), .s1_prev(s1_prev), .s1_addr(s1_addr),
    .s1_wdata(s1_wdata), .s1_mask(s1_mask)
  );

  pipe_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(s1_kind == K_WRITE), .rd_en(s1_kind == K_READ),
    .addr(s1_addr), .wdata(s1_wdata), .mask(s1_mask), .rdata(rdata)
  );

  pipe_sram_drive u_drv (
    .clk(clk), .rst_n(rst_sync_n),
    .s1_kind(s1_kind), .s1_prev(s1_prev),
    .out_en_n(out_en_n), .doze(doze), .wr_live(wr_live),
    .drv_q(drv_q), .bus_drive(bus_drive)
  );
endmodule

// File: rtl/pipe_sram_chk.sv
module pipe_sram_chk
  import pipe_sram_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_a_n,
  input logic              sel_b,
  input logic              sel_c_n,
  input logic              wr_all_n,
  input logic              out_en_n,
  input logic              doze,
  input cmd_kind_e         s1_kind,
  input cmd_kind_e         s1_prev,
  input logic              drv_q,
  input logic [DATA_W-1:0] rdata,
  input logic              bus_drive
);
  p_read_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_kind == K_READ) |=> drv_q);

  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_kind != K_READ) |=> $stable(rdata));

  p_desel_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a_n && !doze) |=> (s1_kind == K_DESEL));

  p_dsel_extend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_kind == K_DESEL && s1_prev == K_READ) |=> drv_q);

  p_dsel_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_kind == K_DESEL && s1_prev == K_DESEL) |=> !drv_q);

  p_outen_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !bus_drive);

  p_wrcmd_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_a_n && sel_b && !sel_c_n && !wr_all_n) |-> !bus_drive);

  p_write_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_kind == K_WRITE) |=> !drv_q);

  p_doze_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    doze |-> !bus_drive);

  p_doze_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    doze |=> (s1_kind == K_SLEEP));

  p_doze_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_kind == K_SLEEP) |=> $stable(rdata));
endmodule

bind pipe_sram pipe_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
  .wr_all_n(wr_all_n), .out_en_n(out_en_n), .doze(doze),
  .s1_kind(s1_kind), .s1_prev(s1_prev), .drv_q(drv_q),
  .rdata(rdata), .bus_drive(bus_drive)
);

// File: tb/tb_pipe_sram.sv
`timescale 1ns/1ps
module tb_pipe_sram;
  localparam int AW = 6, LN = 4, LW = 9, DW = LN * LW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          sel_a_n = 1'b1, sel_b = 1'b1, sel_c_n = 1'b0;
  logic          wr_all_n = 1'b1, wr_lane_gate_n = 1'b1;
  logic [LN-1:0] wr_lane_n = '1;
  logic          out_en_n = 1'b0, doze = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          bus_drive;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pipe_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .wr_all_n(wr_all_n), .wr_lane_gate_n(wr_lane_gate_n), .wr_lane_n(wr_lane_n),
    .out_en_n(out_en_n), .doze(doze), .wdata(wdata),
    .rdata(rdata), .bus_drive(bus_drive)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put(input logic ca, input logic cb, input logic cc, input logic all_n,
                     input logic gate_n, input logic [LN-1:0] ln, input logic [AW-1:0] a,
                     input logic [DW-1:0] d);
    sel_a_n = ca; sel_b = cb; sel_c_n = cc;
    wr_all_n = all_n; wr_lane_gate_n = gate_n; wr_lane_n = ln;
    addr = a; wdata = d;
  endtask

  task automatic wr_full(input logic [AW-1:0] a, input logic [DW-1:0] d);
    put(0, 1, 0, 0, 1, '1, a, d); tick;
  endtask
  task automatic rd(input logic [AW-1:0] a);
    put(0, 1, 0, 1, 1, '1, a, '0); tick;
  endtask
  task automatic desel;
    put(1, 1, 0, 1, 1, '1, '0, '0); tick;
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                          input logic [LN-1:0] m);
    logic [DW-1:0] r = o;
    for (int l = 0; l < LN; l++)
      if (m[l]) r[l*LW +: LW] = n[l*LW +: LW];
    return r;
  endfunction

  task automatic t_reset;
    rst_n = 1'b0; tick; tick;
    chk("R1 drive in reset", {35'd0, bus_drive}, '0);
    rst_n = 1'b1; tick; tick; tick; tick;
    chk("R1 drive after reset", {35'd0, bus_drive}, '0);
    chk("R1 rdata after reset", rdata, '0);
  endtask

  task automatic t_latency;
    wr_full(5, 36'h9_1234_5678);
    rd(5);
    chk("R2 rdata not ready after one edge", rdata, '0);
    desel;
    chk("R11 write then immediate read", rdata, 36'h9_1234_5678);
    chk("R2 drive after read", {35'd0, bus_drive}, 36'd1);
    wr_full(10, 36'hA_AAAA_0001);
    wr_full(11, 36'h5_5555_0002);
    rd(10); rd(11);
    chk("R2 pipelined first read", rdata, 36'hA_AAAA_0001);
    desel;
    chk("R2 pipelined second read", rdata, 36'h5_5555_0002);
    desel; desel;
  endtask

  task automatic t_lanes;
    logic [DW-1:0] old_w = 36'hF_0F0F_0F0F, new_w = 36'h1_2345_6789;
    wr_full(7, old_w);
    put(0, 1, 0, 1, 0, 4'b1010, 7, new_w); tick;
    rd(7); desel;
    chk("R5 lane write lanes 0 and 2", rdata, merge(old_w, new_w, 4'b0101));
    put(0, 1, 0, 0, 0, 4'b1111, 7, 36'hC_3C3C_3C3C); tick;
    rd(7); desel;
    chk("R4 all-lanes strobe overrides", rdata, 36'hC_3C3C_3C3C);
    put(0, 1, 0, 1, 1, 4'b0000, 7, 36'h0_DEAD_BEEF); tick;
    put(0, 1, 0, 1, 0, 4'b1111, 7, 36'h0_DEAD_BEEF); tick;
    chk("R6 ungated strobes act as read", rdata, 36'hC_3C3C_3C3C);
    rd(7); desel;
    chk("R6 array unchanged", rdata, 36'hC_3C3C_3C3C);
    desel; desel;
  endtask

  task automatic t_select;
    put(1, 1, 0, 0, 1, '1, 7, 36'h1_1111_1111); tick;
    put(0, 0, 0, 0, 1, '1, 7, 36'h2_2222_2222); tick;
    put(0, 1, 1, 0, 1, '1, 7, 36'h3_3333_3333); tick;
    put(0, 0, 0, 1, 1, '1, 7, '0); tick; tick;
    chk("R3 deselected read drives nothing", {35'd0, bus_drive}, '0);
    rd(7); desel;
    chk("R3 deselected writes ignored", rdata, 36'hC_3C3C_3C3C);
    desel; desel;
  endtask

  task automatic t_double_deselect;
    wr_full(30, 36'h7_0000_1234);
    rd(30);
    desel;
    chk("R7 drive after read edge", {35'd0, bus_drive}, 36'd1);
    desel;
    chk("R7 drive held one extra cycle", {35'd0, bus_drive}, 36'd1);
    chk("R7 rdata held", rdata, 36'h7_0000_1234);
    desel;
    chk("R7 drive off after second deselect", {35'd0, bus_drive}, '0);
  endtask

  task automatic t_outen;
    rd(30); desel;
    out_en_n = 1'b1; #0.5;
    chk("R8 output enable off is immediate", {35'd0, bus_drive}, '0);
    out_en_n = 1'b0; #0.5;
    chk("R8 output enable back on", {35'd0, bus_drive}, 36'd1);
    desel; desel;
  endtask

  task automatic t_write_blank;
    rd(30);
    put(0, 1, 0, 0, 1, '1, 12, 36'h8_0808_0808); #0.5;
    chk("R9 live write blanks drive", {35'd0, bus_drive}, '0);
    tick;
    desel;
    chk("R9 drive low after write captured", {35'd0, bus_drive}, '0);
    rd(12); desel;
    chk("R9 write landed", rdata, 36'h8_0808_0808);
    desel; desel;
  endtask

  task automatic t_doze;
    wr_full(20, 36'h6_6060_6060);
    rd(20); desel;
    doze = 1'b1; #0.5;
    chk("R10 doze blanks drive", {35'd0, bus_drive}, '0);
    put(0, 1, 0, 0, 1, '1, 20, 36'h0_0BAD_0BAD); tick; tick;
    put(0, 1, 0, 1, 1, '1, 21, '0); tick; tick;
    chk("R10 rdata preserved in doze", rdata, 36'h6_6060_6060);
    chk("R10 no drive in doze", {35'd0, bus_drive}, '0);
    doze = 1'b0;
    desel;
    chk("R10 no drive right after wake", {35'd0, bus_drive}, '0);
    rd(20); desel;
    chk("R10 contents preserved", rdata, 36'h6_6060_6060);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset;
    t_latency;
    t_lanes;
    t_select;
    t_double_deselect;
    t_outen;
    t_write_blank;
    t_doze;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule